// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit with HI/LO Result Registers

This unit sits next to a pipeline's execute stage and performs integer multiplication and division over many clock cycles. A single start pulse hands it two 32-bit operands and a 2-bit operation code. The operation is unsigned or signed multiply, or unsigned or signed divide. The operands are latched on that pulse, so the pipeline may reuse its operand buses at once. Multiplication consumes three multiplier bits per iteration. Division produces one quotient bit per iteration by restoring subtraction. Signed operations work on magnitudes, and the signs are fixed in a final cycle.

Results never go to the general register file. They land in two dedicated result registers. After a multiply, HI holds the upper half of the 64-bit product and LO holds the lower half. After a divide, LO holds the quotient and HI holds the remainder. Only one operation runs at a time, and a busy output tells the stall logic to hold the pipeline. A move-from-HI/LO read port takes a request and a select bit. It answers with a valid strobe only when no operation is running, so a requester simply waits for the strobe.

Top module: `iter_muldiv`

## Requirements
- R1: Op code `op_i` is bit 1 = divide (0 = multiply), bit 0 = signed (0 = unsigned). After a multiply, HI = bits 63..32 and LO = bits 31..0 of the exact 64-bit product, with two's complement operands when signed.
- R2: A multiply accepted at a clock edge keeps `busy_o` high for exactly 12 cycles after that edge (11 radix-8 iterations plus one sign-fix cycle), and its result is readable in the first cycle with `busy_o` low.
- R3: After a divide, LO holds the quotient rounded toward zero and HI holds the remainder. The remainder has the sign of the dividend when signed (dividend = quotient * divisor + remainder).
- R4: A divide accepted at a clock edge keeps `busy_o` high for exactly 33 cycles after that edge (32 iterations plus one sign-fix cycle).
- R5: `start_i` is accepted only while `busy_o` is low. A start pulse during a running operation has no effect: the running result is unchanged and no second operation follows.
- R6: A read request (`rd_req_i`, with `rd_hi_i` = 1 selecting HI and 0 selecting LO) gets `rd_valid_o` low while `busy_o` is high. In the first cycle `busy_o` is low, it gets `rd_valid_o` high and `rd_data_o` equal to the new result.
- R7: Operands are captured at the accepting edge. Changes on `opa_i`, `opb_i` or `op_i` during the operation do not alter the result.
- R8: Division by zero takes the normal 33 cycles and raises no error. HI = dividend. LO = 0xFFFFFFFF, except that a signed divide with a negative dividend gives LO = 0x00000001.
- R9: After reset, `busy_o` is low and both HI and LO read as zero.
- R10: Signed 0x80000000 / 0xFFFFFFFF yields LO = 0x80000000 and HI = 0.
- R11: A read granted in the same cycle that a new start is accepted returns the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when not busy |
| op_i | input | 2 | Operation: bit 1 divide, bit 0 signed |
| opa_i | input | 32 | Multiplicand / dividend |
| opb_i | input | 32 | Multiplier / divisor |
| busy_o | output | 1 | Operation in progress; stall request |
| rd_req_i | input | 1 | Move-from-HI/LO request |
| rd_hi_i | input | 1 | Read select: 1 = HI, 0 = LO |
| rd_valid_o | output | 1 | Read granted this cycle |
| rd_data_o | output | 32 | Selected result register |

## Verification
Two functions can meet in one cycle: a start pulse and a read grant, and a start pulse and a running operation. The bench provokes the first by raising a start and a LO read together while the unit is idle. The grant must carry the old result, and the new operation must then still complete with its own value. It provokes the second by pulsing start with other operands in the middle of a busy window. It then judges that the first result survives and that `busy_o` stays low afterwards instead of launching a second run.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
    localparam int OP_DIV_BIT = 1;
    localparam int OP_SGN_BIT = 0;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIX  = 2'd2
    } md_phase_e;
endpackage

// File: rtl/muldiv_mul_step.sv
module muldiv_mul_step #(
    parameter int W     = 64,
    parameter int DIGIT = 3
) (
    input  logic [W-1:0]     acc_i,
    input  logic [W-1:0]     mcand_i,
    input  logic [DIGIT-1:0] digit_i,
    output logic [W-1:0]     acc_o,
    output logic [W-1:0]     mcand_o
);
    logic [W-1:0] pp [DIGIT];

    for (genvar g = 0; g < DIGIT; g++) begin : g_pp
        assign pp[g] = digit_i[g] ? (mcand_i << g) : '0;
    end

    always_comb begin
        acc_o = acc_i;
        for (int k = 0; k < DIGIT; k++) begin
            acc_o = acc_o + pp[k];
        end
        mcand_o = mcand_i << DIGIT;
    end
endmodule

// File: rtl/muldiv_div_step.sv
module muldiv_div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dvsr_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0] trial_d;
    logic [W:0] diff_d;
    logic       fits_d;

    always_comb begin
        trial_d = {rem_i, quo_i[W-1]};
        fits_d  = (trial_d >= {1'b0, dvsr_i});
        diff_d  = trial_d - {1'b0, dvsr_i};
        rem_o   = fits_d ? diff_d[W-1:0] : trial_d[W-1:0];
        quo_o   = {quo_i[W-2:0], fits_d};
    end
endmodule

// File: rtl/muldiv_sign_fix.sv
module muldiv_sign_fix #(
    parameter int W = 32
) (
    input  logic           is_div_i,
    input  logic           neg_main_i,
    input  logic           neg_rem_i,
    input  logic [2*W-1:0] prod_i,
    input  logic [W-1:0]   quo_i,
    input  logic [W-1:0]   rem_i,
    output logic [W-1:0]   hi_o,
    output logic [W-1:0]   lo_o
);
    logic [2*W-1:0] prod_s;
    logic [W-1:0]   quo_s;
    logic [W-1:0]   rem_s;

    always_comb begin
        prod_s = neg_main_i ? (~prod_i + 1'b1) : prod_i;
        quo_s  = neg_main_i ? (~quo_i + 1'b1) : quo_i;
        rem_s  = neg_rem_i ? (~rem_i + 1'b1) : rem_i;
        if (is_div_i) begin
            hi_o = rem_s;
            lo_o = quo_s;
        end else begin
            hi_o = prod_s[2*W-1:W];
            lo_o = prod_s[W-1:0];
        end
    end
endmodule

// File: rtl/iter_muldiv.sv
module iter_muldiv
    import muldiv_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int MUL_DIGIT = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    output logic            busy_o,
    input  logic            rd_req_i,
    input  logic            rd_hi_i,
    output logic            rd_valid_o,
    output logic [XLEN-1:0] rd_data_o
);
    localparam int MUL_ITER = (XLEN + MUL_DIGIT - 1) / MUL_DIGIT;
    localparam int DIV_ITER = XLEN;
    localparam int MAX_ITER = (MUL_ITER > DIV_ITER) ? MUL_ITER : DIV_ITER;
    localparam int CNT_W    = $clog2(MAX_ITER + 1);
    localparam int PW       = 2 * XLEN;

    typedef struct packed {
        md_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic            is_div;
        logic            neg_main;
        logic            neg_rem;
        logic [PW-1:0]   acc;
        logic [PW-1:0]   mcand;
        logic [XLEN-1:0] mplier;
        logic [XLEN-1:0] rem;
        logic [XLEN-1:0] quo;
        logic [XLEN-1:0] dvsr;
        logic [XLEN-1:0] hi;
        logic [XLEN-1:0] lo;
    } md_state_t;

    md_state_t st_q, st_d;

    logic            sgn_op_d;
    logic            a_neg_d, b_neg_d;
    logic [XLEN-1:0] a_mag_d, b_mag_d;
    logic [PW-1:0]   acc_step, mcand_step;
    logic [XLEN-1:0] rem_step, quo_step;
    logic [XLEN-1:0] hi_fix, lo_fix;

    muldiv_mul_step #(.W(PW), .DIGIT(MUL_DIGIT)) u_mul_step (
        .acc_i   (st_q.acc),
        .mcand_i (st_q.mcand),
        .digit_i (st_q.mplier[MUL_DIGIT-1:0]),
        .acc_o   (acc_step),
        .mcand_o (mcand_step)
    );

    muldiv_div_step #(.W(XLEN)) u_div_step (
        .rem_i  (st_q.rem),
        .quo_i  (st_q.quo),
        .dvsr_i (st_q.dvsr),
        .rem_o  (rem_step),
        .quo_o  (quo_step)
    );

    muldiv_sign_fix #(.W(XLEN)) u_sign_fix (
        .is_div_i   (st_q.is_div),
        .neg_main_i (st_q.neg_main),
        .neg_rem_i  (st_q.neg_rem),
        .prod_i     (st_q.acc),
        .quo_i      (st_q.quo),
        .rem_i      (st_q.rem),
        .hi_o       (hi_fix),
        .lo_o       (lo_fix)
    );

    always_comb begin
        st_d     = st_q;
        sgn_op_d = op_i[OP_SGN_BIT];
        a_neg_d  = sgn_op_d & opa_i[XLEN-1];
        b_neg_d  = sgn_op_d & opb_i[XLEN-1];
        a_mag_d  = a_neg_d ? (~opa_i + 1'b1) : opa_i;
        b_mag_d  = b_neg_d ? (~opb_i + 1'b1) : opb_i;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase    = PH_RUN;
                    st_d.is_div   = op_i[OP_DIV_BIT];
                    st_d.neg_main = a_neg_d ^ b_neg_d;
                    st_d.neg_rem  = a_neg_d;
                    st_d.acc      = '0;
                    st_d.mcand    = {{XLEN{1'b0}}, a_mag_d};
                    st_d.mplier   = b_mag_d;
                    st_d.rem      = '0;
                    st_d.quo      = a_mag_d;
                    st_d.dvsr     = b_mag_d;
                    st_d.cnt      = op_i[OP_DIV_BIT] ? CNT_W'(DIV_ITER - 1)
                                                     : CNT_W'(MUL_ITER - 1);
                end
            end
            PH_RUN: begin
                if (st_q.is_div) begin
                    st_d.rem = rem_step;
                    st_d.quo = quo_step;
                end else begin
                    st_d.acc    = acc_step;
                    st_d.mcand  = mcand_step;
                    st_d.mplier = st_q.mplier >> MUL_DIGIT;
                end
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_FIX;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_FIX: begin
                st_d.hi    = hi_fix;
                st_d.lo    = lo_fix;
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o     = (st_q.phase != PH_IDLE);
    assign rd_valid_o = rd_req_i & (st_q.phase == PH_IDLE);
    assign rd_data_o  = rd_hi_i ? st_q.hi : st_q.lo;

    // R5: busy only rises after a start pulse seen while idle
    assert_busy_from_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R6: result registers hold still while iterating
    assert_hilo_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN) |=> ($stable(st_q.hi) && $stable(st_q.lo)));

    // R2: multiply never counts beyond its iteration budget
    assert_mul_cnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN && !st_q.is_div) |-> (st_q.cnt < CNT_W'(MUL_ITER)));

    // R4: busy drops only after the sign-fix cycle
    assert_busy_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(st_q.phase) == PH_FIX));

    // R8: a zero divisor drives every quotient bit to one before the fix
    assert_divzero_quo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_FIX && st_q.is_div && st_q.dvsr == '0) |-> (st_q.quo == '1));
endmodule

// File: tb/iter_muldiv_bench.sv
module iter_muldiv_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] opa_i = '0, opb_i = '0;
    logic        busy_o;
    logic        rd_req_i = 1'b0, rd_hi_i = 1'b0;
    logic        rd_valid_o;
    logic [31:0] rd_data_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    iter_muldiv u_iter_muldiv (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o),
        .rd_req_i(rd_req_i), .rd_hi_i(rd_hi_i),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] expect_res(input logic [1:0] op, input logic [31:0] a,
                                               input logic [31:0] b);
        logic [63:0] r;
        if (!op[1]) begin
            if (op[0]) r = {{32{a[31]}}, a} * {{32{b[31]}}, b};
            else       r = {32'b0, a} * {32'b0, b};
        end else if (b == 0) begin
            r = {a, (op[0] && a[31]) ? 32'h1 : 32'hFFFF_FFFF};
        end else if (op[0] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
            r = {32'h0, 32'h8000_0000};
        end else if (op[0]) begin
            int sa, sb;
            sa = a; sb = b;
            r = {32'(sa % sb), 32'(sa / sb)};
        end else begin
            r = {a % b, a / b};
        end
        return r;
    endfunction

    task automatic read_reg(input logic hi, output logic valid, output logic [31:0] data);
        rd_req_i = 1'b1; rd_hi_i = hi;
        #1;
        valid = rd_valid_o; data = rd_data_o;
        @(negedge clk);
        rd_req_i = 1'b0;
    endtask

    task automatic launch(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        op_i = op; opa_i = a; opb_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy_o) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic check_result(input string req, input logic [63:0] exp);
        logic v; logic [31:0] d_hi, d_lo;
        read_reg(1'b1, v, d_hi);
        check({req, " hi valid"}, {63'b0, v}, 64'd1);
        read_reg(1'b0, v, d_lo);
        check({req, " lo valid"}, {63'b0, v}, 64'd1);
        check(req, {d_hi, d_lo}, exp);
    endtask

    task automatic run_case(input string req, input string lat_req, input logic [1:0] op,
                            input logic [31:0] a, input logic [31:0] b);
        int cyc;
        launch(op, a, b);
        wait_idle(cyc);
        check(lat_req, 64'(cyc), op[1] ? 64'd33 : 64'd12);
        check_result(req, expect_res(op, a, b));
    endtask

    task automatic t_reset_r9;
        logic v; logic [31:0] d;
        check("R9 busy", {63'b0, busy_o}, 64'd0);
        read_reg(1'b1, v, d);
        check("R9 hi", {31'b0, v, d}, {31'b0, 1'b1, 32'h0});
        read_reg(1'b0, v, d);
        check("R9 lo", {31'b0, v, d}, {31'b0, 1'b1, 32'h0});
    endtask

    task automatic t_multiply;
        run_case("R1 mulu small", "R2 mulu", 2'b00, 32'd3, 32'd7);
        run_case("R1 mulu max", "R2 mulu", 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_case("R1 muls neg*pos", "R2 muls", 2'b01, 32'hFFFF_FFFD, 32'd1000);
        run_case("R1 muls neg*neg", "R2 muls", 2'b01, 32'h8000_0000, 32'h8000_0000);
        run_case("R1 mulu pattern", "R2 mulu", 2'b00, 32'h1234_5678, 32'h9ABC_DEF1);
    endtask

    task automatic t_divide;
        run_case("R3 divu", "R4 divu", 2'b10, 32'd100, 32'd7);
        run_case("R3 divs neg/pos", "R4 divs", 2'b11, 32'hFFFF_FF9C, 32'd7);
        run_case("R3 divs pos/neg", "R4 divs", 2'b11, 32'd100, 32'hFFFF_FFF9);
        run_case("R3 divu big", "R4 divu", 2'b10, 32'hFFFF_FFFF, 32'h0001_0003);
        run_case("R3 divu small/large", "R4 divu", 2'b10, 32'd5, 32'd9);
        run_case("R10 overflow", "R4 ovf", 2'b11, 32'h8000_0000, 32'hFFFF_FFFF);
    endtask

    task automatic t_divzero_r8;
        run_case("R8 divu by zero", "R8 latency", 2'b10, 32'h0000_1234, 32'd0);
        run_case("R8 divs pos by zero", "R8 latency", 2'b11, 32'h7000_0001, 32'd0);
        run_case("R8 divs neg by zero", "R8 latency", 2'b11, 32'hFFFF_FF00, 32'd0);
    endtask

    task automatic t_operand_change_r7;
        int cyc;
        launch(2'b01, 32'hFFFF_FF85, 32'd321);
        repeat (4) begin
            op_i = 2'b10; opa_i = $urandom; opb_i = $urandom;
            @(negedge clk);
        end
        wait_idle(cyc);
        check_result("R7 mul operands held", expect_res(2'b01, 32'hFFFF_FF85, 32'd321));
    endtask

    task automatic t_start_while_busy_r5;
        int cyc;
        launch(2'b10, 32'd1000, 32'd33);
        repeat (5) @(negedge clk);
        op_i = 2'b00; opa_i = 32'd9; opb_i = 32'd9; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle(cyc);
        check("R5 total busy unchanged", 64'(cyc + 6), 64'd33);
        repeat (3) begin
            check("R5 no second run", {63'b0, busy_o}, 64'd0);
            @(negedge clk);
        end
        check_result("R5 first result kept", expect_res(2'b10, 32'd1000, 32'd33));
    endtask

    task automatic t_read_stall_r6;
        int waited = 0;
        logic granted = 1'b0;
        launch(2'b00, 32'hDEAD_BEEF, 32'h0000_0101);
        rd_req_i = 1'b1; rd_hi_i = 1'b0;
        while (!granted && waited < 100) begin
            #1;
            if (rd_valid_o) begin
                granted = 1'b1;
                check("R6 grant data", {32'b0, rd_data_o},
                      {32'b0, expect_res(2'b00, 32'hDEAD_BEEF, 32'h0000_0101)[31:0]});
                check("R6 grant with busy low", {63'b0, busy_o}, 64'd0);
            end else begin
                waited++;
                @(negedge clk);
            end
        end
        rd_req_i = 1'b0;
        check("R6 stall cycles", 64'(waited), 64'd12);
        @(negedge clk);
    endtask

    task automatic t_read_with_start_r11;
        int cyc;
        logic [63:0] prev;
        prev = expect_res(2'b00, 32'd6, 32'd7);
        run_case("R11 setup", "R2 setup", 2'b00, 32'd6, 32'd7);
        op_i = 2'b10; opa_i = 32'd90; opb_i = 32'd4; start_i = 1'b1;
        rd_req_i = 1'b1; rd_hi_i = 1'b0;
        #1;
        check("R11 valid", {63'b0, rd_valid_o}, 64'd1);
        check("R11 old lo", {32'b0, rd_data_o}, {32'b0, prev[31:0]});
        @(negedge clk);
        start_i = 1'b0; rd_req_i = 1'b0;
        wait_idle(cyc);
        check("R11 new op latency R4", 64'(cyc), 64'd33);
        check_result("R11 new result", expect_res(2'b10, 32'd90, 32'd4));
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r9();
        t_multiply();
        t_divide();
        t_divzero_r8();
        t_operand_change_r7();
        t_start_while_busy_r5();
        t_read_stall_r6();
        t_read_with_start_r11();
        report();
        $finish;
    end
endmodule